// File: doc/BRIEF.md
# Slack-Sampling Delay Profiler

This block estimates how much timing slack remains on one output of a monitored logic module. A selector picks one of several monitored outputs. Each clock the block captures three things: the correct value of that output, its value from the cycle before, and a vector of tap bits. The tap bits are the same output sampled after delays that grow with the tap index. A tap that still holds the stale value marks a delay that ran past the clock edge. The number of such stale taps is the latency figure for that cycle. As the monitored path slows with age, this figure grows.

Only cycles in which the selected output really toggled produce a measurement, so idle cycles do not bias the result. The block adds up a fixed power-of-two number of measurements and reports their mean with a plain right shift. It then starts the next window at once. The delay chain that produces the tap bits sits outside this block, and trend analysis of the reported means is left to a consumer downstream.

Top module: `slack_profiler`

## Requirements
- R1: While reset is asserted and just after it is released, `sample_valid` is 0 and `mean_lat` is 0.
- R2: Only the monitored input chosen by `sel` (index into `mon_in`, bit i = signal i) affects the result. Values and toggles on the other bits of `mon_in` have no effect.
- R3: The latency for one qualifying cycle is the number of set bits in (`taps` XOR the captured value of the selected signal) over all `N_TAPS` taps (16 by default). A tap equal to the captured value counts 0, and a differing tap counts 1, whatever its position.
- R4: A cycle is measured only when the selected signal's captured value differs from its value one cycle earlier. Idle cycles, the first cycle after reset and the first cycle after a new selection are ignored.
- R5: One sample is formed from exactly 2^`WIN_LOG2` (4096 by default) measurements. The reported mean is their sum shifted right by `WIN_LOG2`, truncated.
- R6: `sample_valid` is high for exactly one cycle. It is visible after the third rising edge counted from the edge that captures the final measurement of the window. `mean_lat` keeps its value until the next sample.
- R7: The sum does not overflow: a window in which every tap is stale reports a mean of `N_TAPS`.
- R8: When `sel` changes, the partial window is discarded and counting restarts from zero on the new signal. No sample is reported from the old partial window.
- R9: After a sample, the next window begins on the following measurement with an empty sum, so back-to-back windows report their own means.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | SEL_W (3) | Index of the monitored signal to profile |
| mon_in | input | N_SIG (8) | Correctly timed values of the monitored outputs |
| taps | input | N_TAPS (16) | Selected output seen through increasing delays, bit i after i stages |
| sample_valid | output | 1 | One-cycle pulse when a new mean is ready |
| mean_lat | output | LAT_W (5) | Mean stale-tap count of the last completed window |

## Verification
The bench drives windows that mix two latency values so that the sum is not a multiple of the window. A design that rounds, or that divides by the wrong power of two, reports the wrong mean. It also places idle cycles between the toggles, with all taps stale and the other monitored bits changing at random. A design that counts idle cycles, or reads the wrong signal, shifts the mean and sends its pulse early. The bench switches `sel` partway through a window, onto a signal whose value is the inverse of the old one. A design that keeps the partial sum, or that takes the cross-signal difference as a transition, pulses early or reports a mean inflated by the old latency. All-stale windows expose a sum register too narrow to hold the total. Sparse tap patterns expose a latency taken as a thermometer position rather than a bit count.

// File: rtl/slack_pkg.sv
package slack_pkg;

  // Default geometry of the profiler
  localparam int unsigned DEF_SIGS     = 8;
  localparam int unsigned DEF_TAPS     = 16;
  localparam int unsigned DEF_WIN_LOG2 = 12;

  // Bits needed to hold a count from 0 to n inclusive
  function automatic int unsigned count_width(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  // Bits needed to index n items
  function automatic int unsigned index_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/slack_capture.sv
// Selection stage plus the tap, current-value and previous-value registers.
module slack_capture
  import slack_pkg::*;
#(
  parameter int unsigned N_SIG  = DEF_SIGS,
  parameter int unsigned N_TAPS = DEF_TAPS,
  localparam int unsigned SEL_W = index_width(N_SIG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel,
  input  logic [N_SIG-1:0]  mon_in,
  input  logic [N_TAPS-1:0] taps,
  output logic [N_TAPS-1:0] mism,
  output logic              qual,
  output logic              flush
);

  logic [N_TAPS-1:0] tap_q,  tap_d;
  logic              cur_q,  cur_d;
  logic              prev_q, prev_d;
  logic [SEL_W-1:0]  ssel_q, ssel_d;
  logic              warm_q, warm_d;
  logic              pair_q, pair_d;
  logic              pick;

  // Selection logic: the only part that scales with N_SIG
  always_comb begin
    pick = 1'b0;
    for (int i = 0; i < N_SIG; i++) begin
      if (sel == SEL_W'(i)) pick = mon_in[i];
    end
  end

  assign flush = (sel != ssel_q);

  always_comb begin
    tap_d  = taps;
    cur_d  = pick;
    prev_d = cur_q;
    ssel_d = sel;
    warm_d = 1'b1;
    pair_d = warm_q & ~flush;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q  <= '0;
      cur_q  <= 1'b0;
      prev_q <= 1'b0;
      ssel_q <= '0;
      warm_q <= 1'b0;
      pair_q <= 1'b0;
    end else begin
      tap_q  <= tap_d;
      cur_q  <= cur_d;
      prev_q <= prev_d;
      ssel_q <= ssel_d;
      warm_q <= warm_d;
      pair_q <= pair_d;
    end
  end

  // Per-tap comparison with the correctly captured value
  for (genvar t = 0; t < N_TAPS; t++) begin : g_cmp
    assign mism[t] = tap_q[t] ^ cur_q;
  end

  assign qual = pair_q & (cur_q ^ prev_q);

endmodule

// File: rtl/slack_latency.sv
// Counts stale taps for one cycle and registers the measurement.
module slack_latency
  import slack_pkg::*;
#(
  parameter int unsigned N_TAPS = DEF_TAPS,
  localparam int unsigned LAT_W = count_width(N_TAPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TAPS-1:0] mism,
  input  logic              qual,
  input  logic              flush,
  output logic [LAT_W-1:0]  lat,
  output logic              lat_vld
);

  logic [LAT_W-1:0] ones;
  logic [LAT_W-1:0] lat_q, lat_d;
  logic             vld_q, vld_d;

  always_comb begin
    ones = '0;
    for (int i = 0; i < N_TAPS; i++) begin
      ones = ones + LAT_W'(mism[i]);
    end
  end

  always_comb begin
    vld_d = qual & ~flush;
    lat_d = qual ? ones : lat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      vld_q <= 1'b0;
    end else begin
      lat_q <= lat_d;
      vld_q <= vld_d;
    end
  end

  assign lat     = lat_q;
  assign lat_vld = vld_q;

endmodule

// File: rtl/slack_accum.sv
// Sums a power-of-two window of measurements and reports the mean.
module slack_accum
  import slack_pkg::*;
#(
  parameter int unsigned LAT_W    = 5,
  parameter int unsigned WIN_LOG2 = DEF_WIN_LOG2,
  localparam int unsigned ACC_W   = LAT_W + WIN_LOG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LAT_W-1:0] lat,
  input  logic             lat_vld,
  input  logic             flush,
  output logic             sample_valid,
  output logic [LAT_W-1:0] mean_lat
);

  logic [ACC_W-1:0]    acc_q,  acc_d;
  logic [WIN_LOG2-1:0] cnt_q,  cnt_d;
  logic [LAT_W-1:0]    mean_q, mean_d;
  logic                sv_q,   sv_d;
  logic [ACC_W-1:0]    sum;
  logic                last;

  assign sum  = acc_q + ACC_W'(lat);
  assign last = &cnt_q;

  always_comb begin
    acc_d  = acc_q;
    cnt_d  = cnt_q;
    mean_d = mean_q;
    sv_d   = 1'b0;
    if (flush) begin
      acc_d = '0;
      cnt_d = '0;
    end else if (lat_vld) begin
      if (last) begin
        mean_d = sum[ACC_W-1:WIN_LOG2];
        sv_d   = 1'b1;
        acc_d  = '0;
        cnt_d  = '0;
      end else begin
        acc_d = sum;
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      mean_q <= '0;
      sv_q   <= 1'b0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
      sv_q  <= sv_d;
      if (sv_d) mean_q <= mean_d;
    end
  end

  assign sample_valid = sv_q;
  assign mean_lat     = mean_q;

endmodule

// File: rtl/slack_profiler.sv
module slack_profiler
  import slack_pkg::*;
#(
  parameter int unsigned N_SIG    = DEF_SIGS,
  parameter int unsigned N_TAPS   = DEF_TAPS,
  parameter int unsigned WIN_LOG2 = DEF_WIN_LOG2,
  localparam int unsigned SEL_W   = index_width(N_SIG),
  localparam int unsigned LAT_W   = count_width(N_TAPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel,
  input  logic [N_SIG-1:0]  mon_in,
  input  logic [N_TAPS-1:0] taps,
  output logic              sample_valid,
  output logic [LAT_W-1:0]  mean_lat
);

  logic [N_TAPS-1:0] mism;
  logic              qual;
  logic              sel_flush;
  logic [LAT_W-1:0]  lat;
  logic              lat_vld;

  slack_capture #(.N_SIG(N_SIG), .N_TAPS(N_TAPS)) u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (sel),
    .mon_in(mon_in),
    .taps  (taps),
    .mism  (mism),
    .qual  (qual),
    .flush (sel_flush)
  );

  slack_latency #(.N_TAPS(N_TAPS)) u_lat (
    .clk    (clk),
    .rst_n  (rst_n),
    .mism   (mism),
    .qual   (qual),
    .flush  (sel_flush),
    .lat    (lat),
    .lat_vld(lat_vld)
  );

  slack_accum #(.LAT_W(LAT_W), .WIN_LOG2(WIN_LOG2)) u_acc (
    .clk         (clk),
    .rst_n       (rst_n),
    .lat         (lat),
    .lat_vld     (lat_vld),
    .flush       (sel_flush),
    .sample_valid(sample_valid),
    .mean_lat    (mean_lat)
  );

endmodule

// File: rtl/slack_profiler_chk.sv
module slack_profiler_chk #(
  parameter int unsigned N_TAPS = 16,
  parameter int unsigned LAT_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_valid,
  input logic [LAT_W-1:0] mean_lat,
  input logic             lat_vld,
  input logic             flush,
  input logic             qual
);

  // R6
  sv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

  // R6
  mean_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |-> $stable(mean_lat));

  // R7
  mean_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mean_lat <= LAT_W'(N_TAPS));

  // R8
  flush_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !sample_valid);

  // R5
  sv_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> $past(lat_vld));

  // R4
  idle_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !qual |=> !lat_vld);

endmodule

bind slack_profiler slack_profiler_chk #(.N_TAPS(N_TAPS), .LAT_W(LAT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sample_valid(sample_valid),
  .mean_lat    (mean_lat),
  .lat_vld     (lat_vld),
  .flush       (sel_flush),
  .qual        (qual)
);

// File: tb/tb_slack_profiler.sv
module tb_slack_profiler;

  localparam int N_SIG  = 8;
  localparam int N_TAPS = 16;
  localparam int WIN    = 4096;

  logic              clk;
  logic              rst_n;
  logic [2:0]        sel;
  logic [N_SIG-1:0]  mon_in;
  logic [N_TAPS-1:0] taps;
  logic              sample_valid;
  logic [4:0]        mean_lat;

  int n_chk, n_err, pulses;
  logic cur;

  slack_profiler dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .mon_in(mon_in), .taps(taps),
    .sample_valid(sample_valid), .mean_lat(mean_lat)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) if (rst_n && sample_valid) pulses++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [N_TAPS-1:0] late(input int k);
    logic [N_TAPS-1:0] m;
    m = '1;
    return (k == 0) ? '0 : (m << (N_TAPS - k));
  endfunction

  // Drive one cycle; mm is the wanted mismatch against the selected value
  task automatic step(input bit tog, input logic [N_TAPS-1:0] mm, input bit noise);
    if (tog) cur = ~cur;
    if (noise) mon_in = N_SIG'($urandom());
    mon_in[sel] = cur;
    taps = mm ^ {N_TAPS{cur}};
    @(negedge clk);
  endtask

  task automatic run_window(input logic [N_TAPS-1:0] ma, input logic [N_TAPS-1:0] mb,
                            input int na, input bit idle, input int exp, input string req);
    int p0;
    p0 = pulses;
    for (int i = 0; i < WIN; i++) begin
      if (idle && (i % 3 == 1)) step(1'b0, '1, 1'b1);
      step(1'b1, (i < na) ? ma : mb, idle);
    end
    chk(pulses == p0, {req, " no early pulse"}, pulses - p0, 0);
    chk(sample_valid == 1'b0, {req, " pulse not yet"}, sample_valid, 0);
    step(1'b0, '0, 1'b0);
    chk(sample_valid == 1'b0, {req, " pulse not yet"}, sample_valid, 0);
    step(1'b0, '0, 1'b0);
    chk(sample_valid == 1'b1, {req, " R6 pulse timing"}, sample_valid, 1);
    chk(mean_lat == 5'(exp), {req, " mean"}, mean_lat, exp);
    step(1'b0, '0, 1'b0);
    chk(sample_valid == 1'b0, {req, " R6 single pulse"}, sample_valid, 0);
    chk(mean_lat == 5'(exp), {req, " R6 mean held"}, mean_lat, exp);
    chk(pulses == p0 + 1, {req, " pulse count"}, pulses - p0, 1);
  endtask

  task automatic t_reset;
    chk(sample_valid == 1'b0, "R1 valid in reset", sample_valid, 0);
    chk(mean_lat == 5'd0, "R1 mean in reset", mean_lat, 0);
    rst_n = 1'b1;
    step(1'b0, '1, 1'b0);
    step(1'b0, '1, 1'b0);
    chk(sample_valid == 1'b0, "R1 valid after reset", sample_valid, 0);
    chk(mean_lat == 5'd0, "R1 mean after reset", mean_lat, 0);
  endtask

  task automatic t_const;   run_window(late(3), late(3), WIN, 1'b0, 3, "R3 R5 constant"); endtask
  task automatic t_next;    run_window(late(7), late(7), WIN, 1'b0, 7, "R9 back-to-back"); endtask
  task automatic t_trunc;   run_window(late(2), late(5), WIN / 2, 1'b0, 3, "R5 truncation"); endtask
  task automatic t_scatter; run_window(16'hA5A5, 16'h0100, WIN / 2, 1'b0, 4, "R3 scattered taps"); endtask
  task automatic t_idle;    run_window(late(6), late(6), WIN, 1'b1, 6, "R4 R2 idle and noise"); endtask
  task automatic t_max;     run_window('1, '1, WIN, 1'b0, 16, "R7 all stale"); endtask
  task automatic t_zero;    run_window('0, '0, WIN, 1'b0, 0, "R3 no stale"); endtask

  task automatic t_selchg;
    for (int i = 0; i < 2000; i++) step(1'b1, late(10), 1'b0);
    sel = 3'd3;
    cur = ~cur;
    step(1'b0, '1, 1'b0);
    run_window(late(1), late(1), WIN, 1'b0, 1, "R8 selection change");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    n_chk = 0; n_err = 0; pulses = 0;
    rst_n = 1'b0; sel = 3'd0; mon_in = '0; taps = '0; cur = 1'b0;
    repeat (3) @(negedge clk);
    t_reset;
    t_const;
    t_next;
    t_trunc;
    t_scatter;
    t_idle;
    t_max;
    t_zero;
    t_selchg;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule